// File: doc/BRIEF.md
# Endpoint packet buffer with automatic ping-pong banking

This block holds packet data for the nine endpoints of a full-speed USB device function. Each endpoint owns a private byte store, a direction and a max-packet size. Endpoint 0 has a 64-byte store and endpoints 1 to 8 have 128 bytes each. A configuration write sets the direction and the max-packet size. Endpoint 0 carries control traffic, so its direction is rewritten at each control stage. Endpoints 1 to 8 carry interrupt, bulk or isochronous traffic in one fixed direction. The block does not distinguish between these transfer types.

On every configuration write, the block compares the max-packet size with the store. When twice the max-packet size fits in the store, the endpoint runs as two alternating banks of half the store each. Otherwise it runs as one bank spanning the whole store. The serial-engine side and the CPU/DMA side each have a byte write port, a packet commit strobe and a byte read port, and each side selects an endpoint with a 4-bit number. The direction decides which side produces data and which side consumes it. Per-endpoint status flags show full, empty, packet-ready, NAK-needed and the banking mode.

Each bank is a four-state machine:
- **FREE**: the bank is empty.
- **FILL**: some bytes are written, but no packet is committed yet.
- **READY**: a packet is committed and nothing has been read.
- **DRAIN**: the consumer has read part of the packet.

The bank moves between these states as follows:
- FREE→FILL: the producer writes a byte.
- FREE/FILL→READY: the byte count reaches the packet limit, or the producer commits.
- READY→DRAIN: the consumer reads a byte that is not the last one.
- READY/DRAIN→FREE: the consumer reads the last byte. A read of a zero-length packet also releases the bank.
- any state→FREE: a configuration write flushes the bank.

A write pointer and a read pointer select the active bank. Each pointer toggles when its bank completes, but only in double mode.

Top module: `usb_ep_buffer`

## Requirements
- R1: Endpoint 0 has a 64-byte store and endpoints 1 to 8 have 128-byte stores. With single banking and a max-packet size of 200, endpoint 0 auto-commits a packet after exactly 64 bytes.
- R2: `ep_dbl[i]` is 1 exactly when 2 × max-packet size is less than or equal to the store size of endpoint i. In that mode the endpoint has two banks of half the store. Otherwise it has one bank of the whole store.
- R3: With `cfg_dir_in`=1 (IN), the CPU side produces and the packet side consumes. With `cfg_dir_in`=0 (OUT), the packet side produces and the CPU side consumes. Write and commit strobes from the consuming side have no effect.
- R4: A packet is committed automatically when the producer's byte count reaches the smaller of the max-packet size and the bank size.
- R5: A commit strobe from the producing side commits a short packet of the bytes written so far. This includes a zero-length packet.
- R6: `ep_ready[i]` stays 0 until a packet is committed. Once a packet is committed, the consumer's read-data port shows the bytes in write order, and the consumer's avail port gives the bytes still unread. Reading the last byte releases the bank.
- R7: In double mode, two packets can be held at once, and they are drained in the order they were committed.
- R8: `ep_full[i]` is 1 when the current write bank holds a committed packet, and producer writes are then ignored. `ep_nak[i]` is 1 when the endpoint is OUT and full.
- R9: `ep_empty[i]` is 1 when no bank holds any byte or any committed packet.
- R10: Every configuration write to an endpoint flushes both of its banks and returns both of its bank pointers to bank 0.
- R11: After reset, every endpoint is OUT with a max-packet size equal to its store size. It is single-banked, empty, not ready and not full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ep | input | 4 | Endpoint being configured |
| cfg_dir_in | input | 1 | 1 = IN, 0 = OUT |
| cfg_maxp | input | 8 | Max-packet size in bytes |
| pkt_ep | input | 4 | Endpoint selected by the serial-engine side |
| pkt_wr | input | 1 | Serial side byte write (OUT endpoints) |
| pkt_wdata | input | 8 | Serial side write byte |
| pkt_commit | input | 1 | Serial side short-packet commit |
| pkt_rd | input | 1 | Serial side byte read strobe (IN endpoints) |
| pkt_rdata | output | 8 | Byte at the read position of the selected endpoint |
| pkt_avail | output | 8 | Unread bytes of the ready packet of the selected endpoint |
| cpu_ep | input | 4 | Endpoint selected by the CPU/DMA side |
| cpu_wr | input | 1 | CPU side byte write (IN endpoints) |
| cpu_wdata | input | 8 | CPU side write byte |
| cpu_commit | input | 1 | CPU side short-packet commit |
| cpu_rd | input | 1 | CPU side byte read strobe (OUT endpoints) |
| cpu_rdata | output | 8 | Byte at the read position of the selected endpoint |
| cpu_avail | output | 8 | Unread bytes of the ready packet of the selected endpoint |
| ep_dbl | output | 9 | Per-endpoint double-bank mode |
| ep_full | output | 9 | Per-endpoint no free write bank |
| ep_empty | output | 9 | Per-endpoint nothing stored |
| ep_ready | output | 9 | Per-endpoint packet available to the consumer |
| ep_nak | output | 9 | Per-endpoint OUT and full |

## Verification
The bench probes the mode threshold on both sides of the half-store boundary, on endpoint 0 and on a 128-byte endpoint. An off-by-one compare there would give the wrong banking mode. It checks that a packet is committed at exactly the packet limit, including when the max-packet size is larger than the store. A design that compared against the raw max-packet size would then overrun the store. It fills two packets back to back in double mode and checks that they drain in order. A design whose pointer toggled at the wrong event would return the second packet first or report full too early.

Further cases cover the zero-length commit, writes while full, writes from the consuming side and a flush caused by a configuration change. Each of these exposes a design that leaked a stale byte count or kept stale status after the event.

// File: rtl/usb_epbuf_pkg.sv
package usb_epbuf_pkg;
    localparam int NUM_EP    = 9;
    localparam int EPSEL_W   = 4;
    localparam int EP0_BYTES = 64;
    localparam int EPN_BYTES = 128;
    localparam int MAXP_W    = 8;
    localparam int DATA_W    = 8;

    typedef enum logic [1:0] {
        BK_FREE,
        BK_FILL,
        BK_READY,
        BK_DRAIN
    } bank_state_e;
endpackage

// File: rtl/usb_epbuf_bank.sv
module usb_epbuf_bank
    import usb_epbuf_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          wr_en,
    input  logic          commit,
    input  logic          rd_en,
    input  logic [CW-1:0] limit,
    output bank_state_e   state,
    output logic [CW-1:0] wcnt,
    output logic [CW-1:0] rcnt,
    output logic [CW-1:0] len,
    output logic          fill_done,
    output logic          drain_done
);
    bank_state_e   state_n;
    logic [CW-1:0] wcnt_n, rcnt_n, len_n;
    logic [CW-1:0] wnext, rnext;

    assign wnext = wcnt + 1'b1;
    assign rnext = rcnt + 1'b1;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= BK_FREE;
            wcnt  <= '0;
            rcnt  <= '0;
            len   <= '0;
        end else begin
            state <= state_n;
            wcnt  <= wcnt_n;
            rcnt  <= rcnt_n;
            len   <= len_n;
        end
    end

    // next state and counters
    always_comb begin
        state_n = state;
        wcnt_n  = wcnt;
        rcnt_n  = rcnt;
        len_n   = len;
        if (flush) begin
            state_n = BK_FREE;
            wcnt_n  = '0;
            rcnt_n  = '0;
            len_n   = '0;
        end else begin
            unique case (state)
                BK_FREE, BK_FILL: begin
                    if (wr_en) begin
                        if (wnext >= limit) begin
                            state_n = BK_READY;
                            len_n   = wnext;
                            wcnt_n  = '0;
                        end else begin
                            state_n = BK_FILL;
                            wcnt_n  = wnext;
                        end
                    end else if (commit) begin
                        state_n = BK_READY;
                        len_n   = wcnt;
                        wcnt_n  = '0;
                    end
                end
                BK_READY, BK_DRAIN: begin
                    if (rd_en) begin
                        if (rnext >= len) begin
                            state_n = BK_FREE;
                            rcnt_n  = '0;
                            len_n   = '0;
                        end else begin
                            state_n = BK_DRAIN;
                            rcnt_n  = rnext;
                        end
                    end
                end
                default: state_n = BK_FREE;
            endcase
        end
    end

    assign fill_done  = !flush && (state == BK_FREE || state == BK_FILL) && state_n == BK_READY;
    assign drain_done = !flush && (state == BK_READY || state == BK_DRAIN) && state_n == BK_FREE;

    AST_FLUSH_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> state == BK_FREE && wcnt == '0);                              // R10
    AST_READY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BK_READY && $past(state) != BK_READY)
            |-> $past(wr_en || commit));                                         // R6
    AST_LEN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        state == BK_READY |-> len <= limit);                                     // R4
endmodule

// File: rtl/usb_epbuf_slot.sv
module usb_epbuf_slot
    import usb_epbuf_pkg::*;
#(
    parameter int CAP     = 128,
    parameter int MP_W    = MAXP_W,
    parameter int DW      = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_hit,
    input  logic          cfg_dir_in,
    input  logic [MP_W-1:0] cfg_maxp,
    input  logic          pkt_sel,
    input  logic          pkt_wr,
    input  logic [DW-1:0] pkt_wdata,
    input  logic          pkt_commit,
    input  logic          pkt_rd,
    input  logic          cpu_sel,
    input  logic          cpu_wr,
    input  logic [DW-1:0] cpu_wdata,
    input  logic          cpu_commit,
    input  logic          cpu_rd,
    output logic [DW-1:0] rd_data,
    output logic [MP_W-1:0] rd_avail,
    output logic          dbl,
    output logic          full,
    output logic          empty,
    output logic          ready,
    output logic          nak
);
    localparam int AW   = $clog2(CAP);
    localparam int CW   = AW + 1;
    localparam int HALF = CAP / 2;
    localparam logic [MP_W:0] CAP_X  = (MP_W+1)'(CAP);
    localparam logic [MP_W:0] HALF_X = (MP_W+1)'(HALF);

    logic            dir_in;
    logic [MP_W-1:0] maxp;
    logic            wb, rb;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_in <= 1'b0;
            maxp   <= MP_W'(CAP);
        end else if (cfg_hit) begin
            dir_in <= cfg_dir_in;
            maxp   <= cfg_maxp;
        end
    end

    // banking mode and packet limit
    logic [MP_W:0] twice_mp, bsz, lim_w;
    logic [CW-1:0] limit;
    assign twice_mp = {maxp, 1'b0};
    assign dbl      = twice_mp <= CAP_X;
    assign bsz      = dbl ? HALF_X : CAP_X;
    assign lim_w    = ({1'b0, maxp} < bsz) ? {1'b0, maxp} : bsz;
    assign limit    = CW'(lim_w);

    // producer / consumer steering by direction
    logic          prod_wr, prod_commit, cons_rd;
    logic [DW-1:0] prod_data;
    assign prod_wr     = dir_in ? (cpu_sel && cpu_wr)     : (pkt_sel && pkt_wr);
    assign prod_commit = dir_in ? (cpu_sel && cpu_commit) : (pkt_sel && pkt_commit);
    assign prod_data   = dir_in ? cpu_wdata : pkt_wdata;
    assign cons_rd     = dir_in ? (pkt_sel && pkt_rd)     : (cpu_sel && cpu_rd);

    bank_state_e   bst [2];
    logic [CW-1:0] wc  [2];
    logic [CW-1:0] rc  [2];
    logic [CW-1:0] ln  [2];
    logic          fd  [2];
    logic          dd  [2];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        usb_epbuf_bank #(.CW(CW)) i_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .flush      (cfg_hit),
            .wr_en      (prod_wr && (wb == 1'(b))),
            .commit     (prod_commit && (wb == 1'(b))),
            .rd_en      (cons_rd && (rb == 1'(b))),
            .limit      (limit),
            .state      (bst[b]),
            .wcnt       (wc[b]),
            .rcnt       (rc[b]),
            .len        (ln[b]),
            .fill_done  (fd[b]),
            .drain_done (dd[b])
        );
    end

    // bank pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wb <= 1'b0;
            rb <= 1'b0;
        end else if (cfg_hit) begin
            wb <= 1'b0;
            rb <= 1'b0;
        end else if (dbl) begin
            if (fd[wb]) wb <= ~wb;
            if (dd[rb]) rb <= ~rb;
        end
    end

    // byte store
    logic          w_open;
    logic [AW-1:0] waddr, raddr;
    logic [DW-1:0] mem [CAP];

    assign w_open = (bst[wb] == BK_FREE) || (bst[wb] == BK_FILL);
    assign waddr  = wb ? (AW'(HALF) + AW'(wc[wb])) : AW'(wc[wb]);
    assign raddr  = rb ? (AW'(HALF) + AW'(rc[rb])) : AW'(rc[rb]);

    always_ff @(posedge clk) begin
        if (prod_wr && w_open && !cfg_hit) mem[waddr] <= prod_data;
    end

    assign rd_data  = mem[raddr];
    assign ready    = (bst[rb] == BK_READY) || (bst[rb] == BK_DRAIN);
    assign rd_avail = ready ? MP_W'(ln[rb] - rc[rb]) : '0;
    assign full     = !w_open;
    assign empty    = (bst[0] == BK_FREE) && (bst[1] == BK_FREE);
    assign nak      = !dir_in && full;

    AST_SINGLE_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        !dbl |-> (wb == 1'b0 && rb == 1'b0 && bst[1] == BK_FREE));            // R2
    AST_AHEAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rb != wb) |-> bst[rb] != BK_FREE);                                      // R7
    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !cfg_hit && !cons_rd) |=> $stable(ready) && full);              // R8
endmodule

// File: rtl/usb_ep_buffer.sv
module usb_ep_buffer
    import usb_epbuf_pkg::*;
#(
    parameter int N_EP  = NUM_EP,
    parameter int SEL_W = EPSEL_W,
    parameter int CAP0  = EP0_BYTES,
    parameter int CAPN  = EPN_BYTES,
    parameter int MP_W  = MAXP_W,
    parameter int DW    = DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_ep,
    input  logic             cfg_dir_in,
    input  logic [MP_W-1:0]  cfg_maxp,
    input  logic [SEL_W-1:0] pkt_ep,
    input  logic             pkt_wr,
    input  logic [DW-1:0]    pkt_wdata,
    input  logic             pkt_commit,
    input  logic             pkt_rd,
    output logic [DW-1:0]    pkt_rdata,
    output logic [MP_W-1:0]  pkt_avail,
    input  logic [SEL_W-1:0] cpu_ep,
    input  logic             cpu_wr,
    input  logic [DW-1:0]    cpu_wdata,
    input  logic             cpu_commit,
    input  logic             cpu_rd,
    output logic [DW-1:0]    cpu_rdata,
    output logic [MP_W-1:0]  cpu_avail,
    output logic [N_EP-1:0]  ep_dbl,
    output logic [N_EP-1:0]  ep_full,
    output logic [N_EP-1:0]  ep_empty,
    output logic [N_EP-1:0]  ep_ready,
    output logic [N_EP-1:0]  ep_nak
);
    logic [DW-1:0]   rdata_a [N_EP];
    logic [MP_W-1:0] avail_a [N_EP];

    for (genvar i = 0; i < N_EP; i++) begin : g_ep
        localparam int CAP_I = (i == 0) ? CAP0 : CAPN;
        usb_epbuf_slot #(.CAP(CAP_I), .MP_W(MP_W), .DW(DW)) i_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .cfg_hit    (cfg_we && cfg_ep == SEL_W'(i)),
            .cfg_dir_in (cfg_dir_in),
            .cfg_maxp   (cfg_maxp),
            .pkt_sel    (pkt_ep == SEL_W'(i)),
            .pkt_wr     (pkt_wr),
            .pkt_wdata  (pkt_wdata),
            .pkt_commit (pkt_commit),
            .pkt_rd     (pkt_rd),
            .cpu_sel    (cpu_ep == SEL_W'(i)),
            .cpu_wr     (cpu_wr),
            .cpu_wdata  (cpu_wdata),
            .cpu_commit (cpu_commit),
            .cpu_rd     (cpu_rd),
            .rd_data    (rdata_a[i]),
            .rd_avail   (avail_a[i]),
            .dbl        (ep_dbl[i]),
            .full       (ep_full[i]),
            .empty      (ep_empty[i]),
            .ready      (ep_ready[i]),
            .nak        (ep_nak[i])
        );
    end

    always_comb begin
        pkt_rdata = '0;
        pkt_avail = '0;
        cpu_rdata = '0;
        cpu_avail = '0;
        for (int i = 0; i < N_EP; i++) begin
            if (pkt_ep == SEL_W'(i)) begin
                pkt_rdata = rdata_a[i];
                pkt_avail = avail_a[i];
            end
            if (cpu_ep == SEL_W'(i)) begin
                cpu_rdata = rdata_a[i];
                cpu_avail = avail_a[i];
            end
        end
    end
endmodule

// File: tb/test_usb_ep_buffer.sv
module test_usb_ep_buffer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 0, cfg_dir_in = 0;
    logic [3:0] cfg_ep = 0, pkt_ep = 0, cpu_ep = 0;
    logic [7:0] cfg_maxp = 0, pkt_wdata = 0, cpu_wdata = 0;
    logic       pkt_wr = 0, pkt_commit = 0, pkt_rd = 0;
    logic       cpu_wr = 0, cpu_commit = 0, cpu_rd = 0;
    logic [7:0] pkt_rdata, pkt_avail, cpu_rdata, cpu_avail;
    logic [8:0] ep_dbl, ep_full, ep_empty, ep_ready, ep_nak;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    usb_ep_buffer i_usb_ep_buffer (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_ep(cfg_ep), .cfg_dir_in(cfg_dir_in), .cfg_maxp(cfg_maxp),
        .pkt_ep(pkt_ep), .pkt_wr(pkt_wr), .pkt_wdata(pkt_wdata), .pkt_commit(pkt_commit),
        .pkt_rd(pkt_rd), .pkt_rdata(pkt_rdata), .pkt_avail(pkt_avail),
        .cpu_ep(cpu_ep), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_commit(cpu_commit),
        .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .cpu_avail(cpu_avail),
        .ep_dbl(ep_dbl), .ep_full(ep_full), .ep_empty(ep_empty),
        .ep_ready(ep_ready), .ep_nak(ep_nak)
    );

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cfg(int ep, bit din, int mp);
        cfg_ep = 4'(ep); cfg_dir_in = din; cfg_maxp = 8'(mp); cfg_we = 1;
        @(negedge clk); cfg_we = 0;
    endtask

    task automatic pkt_put(int ep, int d);
        pkt_ep = 4'(ep); pkt_wdata = 8'(d); pkt_wr = 1;
        @(negedge clk); pkt_wr = 0;
    endtask

    task automatic cpu_put(int ep, int d);
        cpu_ep = 4'(ep); cpu_wdata = 8'(d); cpu_wr = 1;
        @(negedge clk); cpu_wr = 0;
    endtask

    task automatic cpu_take(int ep, int exp, string req);
        cpu_ep = 4'(ep); #1;
        chk(req, int'(cpu_rdata), exp);
        cpu_rd = 1; @(negedge clk); cpu_rd = 0;
    endtask

    task automatic pkt_take(int ep, int exp, string req);
        pkt_ep = 4'(ep); #1;
        chk(req, int'(pkt_rdata), exp);
        pkt_rd = 1; @(negedge clk); pkt_rd = 0;
    endtask

    task automatic t_reset();
        chk("R11 empty", int'(ep_empty), 9'h1FF);
        chk("R11 ready", int'(ep_ready), 0);
        chk("R11 full", int'(ep_full), 0);
        chk("R11 dbl", int'(ep_dbl), 0);
        chk("R11 nak", int'(ep_nak), 0);
    endtask

    task automatic t_mode();
        cfg(1, 0, 64);  chk("R2 ep1 mp64", int'(ep_dbl[1]), 1);
        cfg(1, 0, 65);  chk("R2 ep1 mp65", int'(ep_dbl[1]), 0);
        cfg(0, 0, 32);  chk("R2 ep0 mp32", int'(ep_dbl[0]), 1);
        cfg(0, 0, 33);  chk("R2 ep0 mp33", int'(ep_dbl[0]), 0);
    endtask

    task automatic t_out_single();
        cfg(2, 0, 100);
        chk("R2 ep2 single", int'(ep_dbl[2]), 0);
        cpu_put(2, 8'h55);                       // consumer-side write on OUT
        chk("R3 cpu write ignored", int'(ep_empty[2]), 1);
        for (int k = 0; k < 99; k++) pkt_put(2, 8'h10 + k);
        chk("R4 not yet committed", int'(ep_ready[2]), 0);
        chk("R9 not empty", int'(ep_empty[2]), 0);
        pkt_put(2, 8'h10 + 99);
        chk("R4 commit at maxp", int'(ep_ready[2]), 1);
        chk("R8 full", int'(ep_full[2]), 1);
        chk("R8 nak", int'(ep_nak[2]), 1);
        pkt_put(2, 8'hEE);                       // write while full
        cpu_ep = 4'd2; #1;
        chk("R8 write while full ignored", int'(cpu_avail), 100);
        for (int k = 0; k < 100; k++) cpu_take(2, 8'h10 + k, "R6 data");
        chk("R6 released", int'(ep_ready[2]), 0);
        chk("R9 empty again", int'(ep_empty[2]), 1);
        chk("R8 not full", int'(ep_full[2]), 0);
    endtask

    task automatic t_in_short();
        cfg(3, 1, 64);
        pkt_put(3, 8'h77);                       // serial-side write on IN
        chk("R3 pkt write ignored", int'(ep_empty[3]), 1);
        for (int k = 0; k < 5; k++) cpu_put(3, 8'hA0 + k);
        chk("R6 no ready before commit", int'(ep_ready[3]), 0);
        cpu_commit = 1; cpu_ep = 4'd3; @(negedge clk); cpu_commit = 0;
        chk("R5 short commit ready", int'(ep_ready[3]), 1);
        pkt_ep = 4'd3; #1;
        chk("R5 short avail", int'(pkt_avail), 5);
        for (int k = 0; k < 5; k++) pkt_take(3, 8'hA0 + k, "R6 IN data");
        chk("R9 IN empty", int'(ep_empty[3]), 1);
        cpu_commit = 1; cpu_ep = 4'd3; @(negedge clk); cpu_commit = 0;
        chk("R5 zlp ready", int'(ep_ready[3]), 1);
        pkt_ep = 4'd3; #1;
        chk("R5 zlp avail", int'(pkt_avail), 0);
        chk("R9 zlp not empty", int'(ep_empty[3]), 0);
        pkt_rd = 1; @(negedge clk); pkt_rd = 0;
        chk("R6 zlp released", int'(ep_ready[3]), 0);
        chk("R9 zlp empty", int'(ep_empty[3]), 1);
    endtask

    task automatic t_dbl_alt();
        cfg(4, 0, 8);
        chk("R2 ep4 double", int'(ep_dbl[4]), 1);
        for (int k = 0; k < 8; k++) pkt_put(4, 8'h40 + k);
        chk("R7 first ready", int'(ep_ready[4]), 1);
        chk("R7 second bank free", int'(ep_full[4]), 0);
        chk("R8 no nak", int'(ep_nak[4]), 0);
        for (int k = 0; k < 8; k++) pkt_put(4, 8'h80 + k);
        chk("R8 both held full", int'(ep_full[4]), 1);
        chk("R8 nak both held", int'(ep_nak[4]), 1);
        for (int k = 0; k < 8; k++) cpu_take(4, 8'h40 + k, "R7 first packet order");
        chk("R7 second ready", int'(ep_ready[4]), 1);
        chk("R7 bank freed", int'(ep_full[4]), 0);
        for (int k = 0; k < 8; k++) cpu_take(4, 8'h80 + k, "R7 second packet order");
        chk("R9 drained", int'(ep_empty[4]), 1);
    endtask

    task automatic t_clamp();
        cfg(0, 0, 200);
        chk("R2 ep0 mp200 single", int'(ep_dbl[0]), 0);
        for (int k = 0; k < 63; k++) pkt_put(0, k);
        chk("R1 63 bytes not committed", int'(ep_ready[0]), 0);
        pkt_put(0, 63);
        chk("R1 commit at store size", int'(ep_ready[0]), 1);
        cpu_ep = 4'd0; #1;
        chk("R4 clamp avail", int'(cpu_avail), 64);
        cfg(0, 0, 200);
        chk("R10 flush ready", int'(ep_ready[0]), 0);
        chk("R10 flush empty", int'(ep_empty[0]), 1);
    endtask

    task automatic t_flush();
        cfg(5, 0, 16);
        for (int k = 0; k < 3; k++) pkt_put(5, 8'hC0 + k);
        pkt_commit = 1; pkt_ep = 4'd5; @(negedge clk); pkt_commit = 0;
        cpu_ep = 4'd5; #1;
        chk("R5 OUT short avail", int'(cpu_avail), 3);
        cpu_take(5, 8'hC0, "R6 OUT short data");
        for (int k = 0; k < 4; k++) pkt_put(5, 8'hD0 + k);
        chk("R9 partial not empty", int'(ep_empty[5]), 0);
        cfg(5, 1, 16);
        chk("R10 both banks flushed", int'(ep_empty[5]), 1);
        chk("R10 no ready", int'(ep_ready[5]), 0);
        for (int k = 0; k < 16; k++) cpu_put(5, 8'hE0 + k);
        pkt_ep = 4'd5; #1;
        chk("R10 pointers restart", int'(pkt_avail), 16);
        pkt_take(5, 8'hE0, "R10 fresh data");
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mode();
        t_out_single();
        t_in_short();
        t_dbl_alt();
        t_clamp();
        t_flush();
        done = 1;
        report();
    end
endmodule